// File: doc/BRIEF.md
# Two-Cycle-ALU Pipeline Hazard Controller

This block decides, every cycle, how the instruction sitting in the decode slot of an in-order six-slot pipeline (fetch, decode, ALU half one, ALU half two, memory, writeback) gets its operands. The integer ALU needs two cycles, so its result exists only at the end of the second ALU half, and conditional branches are resolved in that same slot. The block compares the decode instruction's source register indices with the destinations of older instructions further down. It then either picks a bypass source for each operand, or holds fetch and decode while it injects a bubble into the first ALU half.

The operand muxes sit at the end of decode and feed the decode/ALU pipeline register. A producer in the second ALU half can therefore hand over its result the same cycle, while a producer one slot behind the consumer cannot. A mode input switches between stall-only operation, which relies on a write-then-read register file, and full bypassing. A taken branch in the second ALU half kills the three younger instructions, and the block raises a fetch redirect on the following cycle.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: With `bypass_en`=0, a used decode source whose index matches the destination of a valid writing instruction (class ALU=0 or LOAD=1) in X0, X1 or M raises `stall_f`, `stall_d` and `bubble_x0`. In this mode every select stays at 0 (register file).
- R2: With `bypass_en`=0, a match only against the instruction in W causes no stall.
- R3: With `bypass_en`=1, a match against an ALU instruction in X0 raises all three stall outputs.
- R4: With `bypass_en`=1, a match against an ALU instruction gives select 1 when the producer is in X1, 2 when it is in M and 3 when it is in W, with no stall.
- R5: When several stages match, the youngest producer wins: X1 before M before W.
- R6: With `bypass_en`=1, a LOAD producer in X0, X1 or M stalls the consumer. A LOAD in W is taken through select 3.
- R7: STORE (2) and BRANCH (3) instructions, invalid stages and unused sources never create a dependency.
- R8: For a STORE in decode, the base (source 1) uses `sel_a` and the data (source 2) uses `sel_st`. `sel_b` stays 0. A hazard on either source stalls.
- R9: A valid BRANCH in X1 with `x1_br_taken`=1 raises `squash_f`, `squash_d` and `squash_x0` in the same cycle and forces all stall outputs to 0. With `x1_br_taken`=0 nothing is squashed.
- R10: `redirect` is a register that is 1 exactly in the cycle after a taken branch was seen in X1. Synchronous reset clears it to 0.
- R11: Register index 0 is compared and bypassed like any other index.
- R12: An invalid decode slot never stalls, and all its selects are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bypass_en | input | 1 | 1 = full bypassing, 0 = stall only |
| d_valid | input | 1 | Decode slot holds an instruction |
| d_cls | input | 2 | Decode class: 0 ALU, 1 LOAD, 2 STORE, 3 BRANCH |
| d_rs1 | input | REG_W | Source 1 index (store base) |
| d_rs1_used | input | 1 | Source 1 is read |
| d_rs2 | input | REG_W | Source 2 index (store data) |
| d_rs2_used | input | 1 | Source 2 is read |
| x0_valid | input | 1 | X0 slot valid |
| x0_cls | input | 2 | X0 class |
| x0_rd | input | REG_W | X0 destination |
| x1_valid | input | 1 | X1 slot valid |
| x1_cls | input | 2 | X1 class |
| x1_rd | input | REG_W | X1 destination |
| x1_br_taken | input | 1 | Branch outcome in X1 |
| m_valid | input | 1 | M slot valid |
| m_cls | input | 2 | M class |
| m_rd | input | REG_W | M destination |
| w_valid | input | 1 | W slot valid |
| w_cls | input | 2 | W class |
| w_rd | input | REG_W | W destination |
| sel_a | output | 2 | Operand A source: 0 RF, 1 X1, 2 M, 3 W |
| sel_b | output | 2 | Operand B source, same code |
| sel_st | output | 2 | Store data source, same code |
| stall_f | output | 1 | Hold fetch |
| stall_d | output | 1 | Hold decode |
| bubble_x0 | output | 1 | Insert a bubble into X0 |
| squash_f | output | 1 | Kill the fetch slot |
| squash_d | output | 1 | Kill the decode slot |
| squash_x0 | output | 1 | Kill the X0 slot |
| redirect | output | 1 | Redirect fetch to the branch target |

## Verification
The assertions assume the slot inputs describe a real pipeline: class codes come from the four listed values, and `x1_br_taken` means something only with a valid BRANCH in X1. The stimulus table and the directed tests build every slot through one set of class constants and drive the branch flag only alongside a branch in X1, apart from one vector that keeps it low to check that nothing is squashed. The checks sample only after the inputs have settled, half a clock away from the edge that updates `redirect`.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    CLS_ALU    = 2'd0,
    CLS_LOAD   = 2'd1,
    CLS_STORE  = 2'd2,
    CLS_BRANCH = 2'd3
  } icls_e;

  typedef enum logic [1:0] {
    SRC_RF = 2'd0,
    SRC_X1 = 2'd1,
    SRC_M  = 2'd2,
    SRC_W  = 2'd3
  } opsrc_e;

  localparam int unsigned NUM_PROD = 4;  // X0, X1, M, W
  localparam int unsigned NUM_OPND = 3;  // operand A, operand B, store data
endpackage

// File: rtl/hz_producer.sv
module hz_producer
  import hz_pkg::*;
(
  input  logic       valid,
  input  logic [1:0] cls,
  output logic       writes
);
  // Only ALU results and loaded data land in the register file.
  always_comb begin
    writes = valid && ((cls == CLS_ALU) || (cls == CLS_LOAD));
  end
endmodule

// File: rtl/hz_operand_check.sv
module hz_operand_check
  import hz_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic             bypass_en,
  input  logic             used,
  input  logic [REG_W-1:0] idx,
  input  logic             wr_x0,
  input  logic [REG_W-1:0] rd_x0,
  input  logic             wr_x1,
  input  logic [REG_W-1:0] rd_x1,
  input  logic             ld_x1,
  input  logic             wr_m,
  input  logic [REG_W-1:0] rd_m,
  input  logic             ld_m,
  input  logic             wr_w,
  input  logic [REG_W-1:0] rd_w,
  output logic [1:0]       sel,
  output logic             hazard
);
  logic hit_x0, hit_x1, hit_m, hit_w;

  always_comb begin
    hit_x0 = used && wr_x0 && (rd_x0 == idx);
    hit_x1 = used && wr_x1 && (rd_x1 == idx);
    hit_m  = used && wr_m  && (rd_m  == idx);
    hit_w  = used && wr_w  && (rd_w  == idx);
  end

  always_comb begin
    sel    = SRC_RF;
    hazard = 1'b0;
    if (!bypass_en) begin
      // Write-then-read register file covers a producer in W.
      hazard = hit_x0 || hit_x1 || hit_m;
    end else if (hit_x0) begin
      hazard = 1'b1;
    end else if (hit_x1) begin
      if (ld_x1) hazard = 1'b1;
      else       sel    = SRC_X1;
    end else if (hit_m) begin
      if (ld_m) hazard = 1'b1;
      else      sel    = SRC_M;
    end else if (hit_w) begin
      sel = SRC_W;
    end
  end
endmodule

// File: rtl/hz_flow_ctl.sv
module hz_flow_ctl
  import hz_pkg::*;
#(
  parameter int unsigned N_HAZ = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_HAZ-1:0] opnd_haz,
  input  logic             d_valid,
  input  logic             x1_valid,
  input  logic [1:0]       x1_cls,
  input  logic             x1_br_taken,
  output logic             hold,
  output logic             kill,
  output logic             redirect_q
);
  always_comb begin
    kill = x1_valid && (x1_cls == CLS_BRANCH) && x1_br_taken;
    // The decode instruction is being killed, so holding it is pointless.
    hold = d_valid && (|opnd_haz) && !kill;
  end

  always_ff @(posedge clk) begin
    if (rst) redirect_q <= 1'b0;
    else     redirect_q <= kill;
  end
endmodule

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl
  import hz_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bypass_en,
  input  logic             d_valid,
  input  logic [1:0]       d_cls,
  input  logic [REG_W-1:0] d_rs1,
  input  logic             d_rs1_used,
  input  logic [REG_W-1:0] d_rs2,
  input  logic             d_rs2_used,
  input  logic             x0_valid,
  input  logic [1:0]       x0_cls,
  input  logic [REG_W-1:0] x0_rd,
  input  logic             x1_valid,
  input  logic [1:0]       x1_cls,
  input  logic [REG_W-1:0] x1_rd,
  input  logic             x1_br_taken,
  input  logic             m_valid,
  input  logic [1:0]       m_cls,
  input  logic [REG_W-1:0] m_rd,
  input  logic             w_valid,
  input  logic [1:0]       w_cls,
  input  logic [REG_W-1:0] w_rd,
  output logic [1:0]       sel_a,
  output logic [1:0]       sel_b,
  output logic [1:0]       sel_st,
  output logic             stall_f,
  output logic             stall_d,
  output logic             bubble_x0,
  output logic             squash_f,
  output logic             squash_d,
  output logic             squash_x0,
  output logic             redirect
);
  // Producer decode, one per downstream slot (0 X0, 1 X1, 2 M, 3 W).
  logic [NUM_PROD-1:0] p_valid;
  logic [1:0]          p_cls [NUM_PROD];
  logic [NUM_PROD-1:0] p_wr;

  always_comb begin
    p_valid  = {w_valid, m_valid, x1_valid, x0_valid};
    p_cls[0] = x0_cls;
    p_cls[1] = x1_cls;
    p_cls[2] = m_cls;
    p_cls[3] = w_cls;
  end

  for (genvar g = 0; g < NUM_PROD; g++) begin : g_prod
    hz_producer u_prod (
      .valid  (p_valid[g]),
      .cls    (p_cls[g]),
      .writes (p_wr[g])
    );
  end

  logic ld_x1, ld_m, d_is_store;
  always_comb begin
    ld_x1      = (x1_cls == CLS_LOAD);
    ld_m       = (m_cls == CLS_LOAD);
    d_is_store = (d_cls == CLS_STORE);
  end

  // Operand slots: 0 ALU A (rs1), 1 ALU B (rs2, non-store), 2 store data (rs2).
  logic [REG_W-1:0]    o_idx  [NUM_OPND];
  logic [NUM_OPND-1:0] o_used;
  logic [1:0]          o_sel  [NUM_OPND];
  logic [NUM_OPND-1:0] o_haz;

  always_comb begin
    o_idx[0]  = d_rs1;
    o_idx[1]  = d_rs2;
    o_idx[2]  = d_rs2;
    o_used[0] = d_valid && d_rs1_used;
    o_used[1] = d_valid && d_rs2_used && !d_is_store;
    o_used[2] = d_valid && d_rs2_used && d_is_store;
  end

  for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
    hz_operand_check #(.REG_W(REG_W)) u_chk (
      .bypass_en (bypass_en),
      .used      (o_used[g]),
      .idx       (o_idx[g]),
      .wr_x0     (p_wr[0]),
      .rd_x0     (x0_rd),
      .wr_x1     (p_wr[1]),
      .rd_x1     (x1_rd),
      .ld_x1     (ld_x1),
      .wr_m      (p_wr[2]),
      .rd_m      (m_rd),
      .ld_m      (ld_m),
      .wr_w      (p_wr[3]),
      .rd_w      (w_rd),
      .sel       (o_sel[g]),
      .hazard    (o_haz[g])
    );
  end

  logic hold, kill, redirect_q;

  hz_flow_ctl #(.N_HAZ(NUM_OPND)) u_flow (
    .clk         (clk),
    .rst         (rst),
    .opnd_haz    (o_haz),
    .d_valid     (d_valid),
    .x1_valid    (x1_valid),
    .x1_cls      (x1_cls),
    .x1_br_taken (x1_br_taken),
    .hold        (hold),
    .kill        (kill),
    .redirect_q  (redirect_q)
  );

  always_comb begin
    sel_a     = o_sel[0];
    sel_b     = o_sel[1];
    sel_st    = o_sel[2];
    stall_f   = hold;
    stall_d   = hold;
    bubble_x0 = hold;
    squash_f  = kill;
    squash_d  = kill;
    squash_x0 = kill;
    redirect  = redirect_q;
  end
endmodule

// File: rtl/hz_checker.sv
module hz_checker #(
  parameter int unsigned REG_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             bypass_en,
  input logic             d_valid,
  input logic [1:0]       d_cls,
  input logic [REG_W-1:0] d_rs1,
  input logic             d_rs1_used,
  input logic             x0_valid,
  input logic [1:0]       x0_cls,
  input logic [REG_W-1:0] x0_rd,
  input logic             x1_valid,
  input logic [1:0]       x1_cls,
  input logic [REG_W-1:0] x1_rd,
  input logic [1:0]       sel_a,
  input logic [1:0]       sel_b,
  input logic [1:0]       sel_st,
  input logic             stall_d,
  input logic             bubble_x0,
  input logic             squash_f,
  input logic             squash_x0,
  input logic             redirect
);
  p_stall_mode_rf_r1: assert property (@(posedge clk) disable iff (rst)
    !bypass_en |-> (sel_a == 2'd0 && sel_b == 2'd0 && sel_st == 2'd0));

  p_x0_alu_stall_r3: assert property (@(posedge clk) disable iff (rst)
    (bypass_en && d_valid && d_rs1_used && x0_valid && x0_cls == 2'd0
     && x0_rd == d_rs1 && !squash_x0) |-> (stall_d && bubble_x0));

  p_x1_alu_fwd_r4: assert property (@(posedge clk) disable iff (rst)
    (bypass_en && d_valid && d_rs1_used && x1_valid && x1_cls == 2'd0
     && x1_rd == d_rs1 && !(x0_valid && x0_rd == d_rs1)) |-> (sel_a == 2'd1));

  p_store_b_rf_r8: assert property (@(posedge clk) disable iff (rst)
    (d_cls == 2'd2) |-> (sel_b == 2'd0));

  p_squash_no_stall_r9: assert property (@(posedge clk) disable iff (rst)
    squash_x0 |-> (!stall_d && !bubble_x0));

  p_redirect_set_r10: assert property (@(posedge clk) disable iff (rst)
    squash_f |=> redirect);

  p_redirect_clr_r10: assert property (@(posedge clk) disable iff (rst)
    !squash_f |=> !redirect);

  p_idle_d_r12: assert property (@(posedge clk) disable iff (rst)
    !d_valid |-> (!stall_d && sel_a == 2'd0 && sel_b == 2'd0 && sel_st == 2'd0));
endmodule

bind pipe_hazard_ctl hz_checker #(.REG_W(REG_W)) u_hz_checker (.*);

// File: tb/tb_pipe_hazard_ctl.sv
module tb_pipe_hazard_ctl;
  localparam int RW = 5;
  localparam logic [1:0] A = 2'd0, L = 2'd1, S = 2'd2, B = 2'd3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bypass_en, d_valid, d_rs1_used, d_rs2_used;
  logic x0_valid, x1_valid, x1_br_taken, m_valid, w_valid;
  logic [1:0] d_cls, x0_cls, x1_cls, m_cls, w_cls;
  logic [RW-1:0] d_rs1, d_rs2, x0_rd, x1_rd, m_rd, w_rd;
  logic [1:0] sel_a, sel_b, sel_st;
  logic stall_f, stall_d, bubble_x0, squash_f, squash_d, squash_x0, redirect;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  pipe_hazard_ctl #(.REG_W(RW)) dut (.*);

  typedef struct packed {
    logic byp; logic dv; logic [1:0] dc;
    logic [4:0] rs1; logic u1; logic [4:0] rs2; logic u2;
    logic x0v; logic [1:0] x0c; logic [4:0] x0r;
    logic x1v; logic [1:0] x1c; logic [4:0] x1r; logic brt;
    logic mv; logic [1:0] mc; logic [4:0] mr;
    logic wv; logic [1:0] wc; logic [4:0] wr;
    logic [1:0] ea; logic [1:0] eb; logic [1:0] est; logic estall; logic esq;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    // byp dv dc rs1 u1 rs2 u2 | x0 | x1 brt | m | w | ea eb est stall sq req
    '{0,1,A,3,1,4,1, 1,A,3, 0,A,0,0, 0,A,0, 0,A,0, 0,0,0,1,0, 1},  // R1 X0 match
    '{0,1,A,3,1,4,1, 0,A,0, 1,L,4,0, 0,A,0, 0,A,0, 0,0,0,1,0, 1},  // R1 X1 load
    '{0,1,A,3,1,4,1, 0,A,0, 0,A,0,0, 1,A,3, 1,A,4, 0,0,0,1,0, 1},  // R1 M match, W ignored
    '{0,1,A,3,1,4,1, 0,A,0, 0,A,0,0, 0,A,0, 1,A,3, 0,0,0,0,0, 2},  // R2 W only
    '{1,1,A,3,1,4,1, 1,A,4, 0,A,0,0, 0,A,0, 0,A,0, 0,0,0,1,0, 3},  // R3 X0 ALU
    '{1,1,A,3,1,4,1, 0,A,0, 1,A,3,0, 1,A,4, 0,A,0, 1,2,0,0,0, 4},  // R4 X1 and M
    '{1,1,A,3,1,4,1, 0,A,0, 0,A,0,0, 0,A,0, 1,A,4, 0,3,0,0,0, 4},  // R4 W
    '{1,1,A,3,1,4,1, 0,A,0, 1,A,3,0, 1,A,3, 1,A,3, 1,0,0,0,0, 5},  // R5 X1 wins
    '{1,1,A,3,1,4,1, 0,A,0, 0,A,0,0, 1,A,4, 1,A,4, 0,2,0,0,0, 5},  // R5 M over W
    '{1,1,A,3,1,4,1, 0,A,0, 0,A,0,0, 1,L,3, 0,A,0, 0,0,0,1,0, 6},  // R6 load in M
    '{1,1,A,3,1,4,1, 0,A,0, 1,L,4,0, 0,A,0, 0,A,0, 0,0,0,1,0, 6},  // R6 load in X1
    '{1,1,A,3,1,4,1, 0,A,0, 0,A,0,0, 0,A,0, 1,L,3, 3,0,0,0,0, 6},  // R6 load in W
    '{1,1,A,3,1,4,1, 0,A,0, 1,S,3,0, 1,B,4, 0,A,3, 0,0,0,0,0, 7},  // R7 non-writers
    '{1,1,A,3,0,4,0, 1,A,3, 0,A,0,0, 0,A,0, 0,A,0, 0,0,0,0,0, 7},  // R7 unused
    '{1,1,S,3,1,4,1, 0,A,0, 1,A,3,0, 1,A,4, 0,A,0, 1,0,2,0,0, 8},  // R8 store paths
    '{1,1,S,3,1,4,1, 1,A,4, 0,A,0,0, 0,A,0, 0,A,0, 0,0,0,1,0, 8},  // R8 data hazard
    '{1,1,A,0,1,4,0, 0,A,0, 1,A,0,0, 0,A,0, 0,A,0, 1,0,0,0,0, 11}, // R11 index 0
    '{1,0,A,3,1,4,1, 1,A,3, 0,A,0,0, 1,A,4, 0,A,0, 0,0,0,0,0, 12}  // R12 idle decode
  };

  task automatic apply(input vec_t v);
    bypass_en = v.byp; d_valid = v.dv; d_cls = v.dc;
    d_rs1 = v.rs1; d_rs1_used = v.u1; d_rs2 = v.rs2; d_rs2_used = v.u2;
    x0_valid = v.x0v; x0_cls = v.x0c; x0_rd = v.x0r;
    x1_valid = v.x1v; x1_cls = v.x1c; x1_rd = v.x1r; x1_br_taken = v.brt;
    m_valid = v.mv; m_cls = v.mc; m_rd = v.mr;
    w_valid = v.wv; w_cls = v.wc; w_rd = v.wr;
  endtask

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] pack_out();
    return {3'b0, sel_a, sel_b, sel_st, stall_f, stall_d, bubble_x0,
            squash_f, squash_d, squash_x0, 1'b0};
  endfunction

  function automatic logic [15:0] pack_exp(input vec_t v);
    return {3'b0, v.ea, v.eb, v.est, {3{v.estall}}, {3{v.esq}}, 1'b0};
  endfunction

  localparam vec_t IDLE = '{0,0,A,0,0,0,0, 0,A,0, 0,A,0,0, 0,A,0, 0,A,0, 0,0,0,0,0, 0};

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    vec_t v;
    apply(IDLE);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset redirect", {15'b0, redirect}, 16'h0);
    check("R12 reset idle outputs", pack_out(), 16'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(VECS[i]);
      #2;
      check($sformatf("R%0d vector %0d", VECS[i].req, i), pack_out(), pack_exp(VECS[i]));
    end

    // R9: taken branch in X1 squashes and overrides a pending stall.
    @(negedge clk);
    v = VECS[4];
    v.x1v = 1; v.x1c = B; v.brt = 1;
    apply(v);
    #2;
    v.estall = 0; v.esq = 1;
    check("R9 taken branch squash", pack_out(), pack_exp(v));
    @(posedge clk);
    #2;
    check("R10 redirect after taken", {15'b0, redirect}, 16'h1);

    // R9: branch not taken -> no squash, the stall stays.
    @(negedge clk);
    v = VECS[4];
    v.x1v = 1; v.x1c = B; v.brt = 0;
    apply(v);
    #2;
    check("R9 not taken no squash", pack_out(), pack_exp(VECS[4]));
    @(posedge clk);
    #2;
    check("R10 redirect clears", {15'b0, redirect}, 16'h0);

    // R10: reset clears a pending redirect.
    @(negedge clk);
    apply(IDLE);
    x1_valid = 1; x1_cls = B; x1_br_taken = 1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #2;
    check("R10 reset clears redirect", {15'b0, redirect}, 16'h0);

    @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule